// File: doc/BRIEF.md
# SDRAM Command Timing Monitor

This block sits beside a four-bank SDRAM command bus and only listens. It samples the chip-select, row strobe, column strobe, write-enable, bank-select and auto-precharge address bit on every rising clock edge. It keeps an open/closed state and elapsed-cycle counters for each bank. Every decoded command is checked against the state it needs and against the minimum spacing rules. The spacing rules are parameters given in clock cycles.

A violation sets a sticky flag. It also latches a numeric rule code that identifies the first offending rule, and it increments a saturating counter kept for that rule. A clear input resets the flag, the latched code and every counter. The monitor drives nothing toward the memory. It is meant for simulation benches and for on-chip bus watching during bring-up.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With `cs_n` low, the command is decoded from {`ras_n`,`cas_n`,`we_n`} as follows: 111 no-op, 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode-set, 110 burst stop. With `cs_n` high the cycle is a deselect and has no effect on state or on error reporting.
- R2: An activate to a bank that is already open reports code 3. A read or write to a closed bank reports code 4.
- R3: A refresh or mode-set while any bank is open reports code 2.
- R4: Any command other than no-op or deselect that comes fewer than `T_MRD` cycles after a mode-set reports code 1. With `T_MRD`=2, a command two cycles after the mode-set is legal.
- R5: A read or write that comes fewer than `T_RCD` cycles after the activate of the same bank reports code 6.
- R6: An activate that comes fewer than `T_RP` cycles after that bank was closed reports code 7. The close may come from an explicit precharge or from an auto-precharge.
- R7: An activate to a closed bank that comes fewer than `T_RRD` cycles after an activate of any other bank reports code 8.
- R8: A precharge of an open bank that comes fewer than `T_RAS` cycles after its activate reports code 9.
- R9: An activate to a closed bank that comes fewer than `T_RC` cycles after that bank's previous activate reports code 10.
- R10: A precharge with `ap_bit` high closes every bank whatever `ba` holds. A precharge with `ap_bit` low closes only bank `ba`.
- R11: A read or write with `ap_bit` high to an open bank, with no auto-precharge pending, closes that bank `BURST_LEN` cycles later. That later cycle counts as the close for R6. A read or write to the bank before it closes reports code 5.
- R12: Reads and writes to an open bank may follow each other on consecutive cycles without any report.
- R13: `err_flag` stays set until `clr`. `err_code` holds the lowest code among the violations of the first offending cycle, and it is 0 while the flag is clear. Counter c sits at `err_cnt[(c-1)*CNT_W +: CNT_W]` and saturates. A cycle with `clr` high clears everything and discards that cycle's violations. Reset gives flag 0, code 0 and all counters 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Clears flag, code and counters |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | $clog2(NUM_BANKS) | Bank select |
| ap_bit | input | 1 | Address bit for precharge-all / auto-precharge |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 4 | Code of first violation |
| err_cnt | output | 10*CNT_W | Per-rule saturating violation counters |

## Verification
Directed sequences put each spacing rule one cycle short of its limit and then exactly at it. This separates an off-by-one in the elapsed counters from a correct boundary, and each rule is isolated so that no lower code masks it. Pairs of precharge with and without the auto bit, followed by activates, show whether the close reached every bank or only the addressed one. Auto-precharge bursts are probed inside the burst, just after the close and at the recovery limit. A long weighted-random command stream, with deselects and occasional clears mixed in, is compared cycle by cycle against a timestamp-based model of all rules. This shows up wrong priority among simultaneous violations, counter saturation faults and state leaks across banks.

// File: rtl/sdrchk_pkg.sv
package sdrchk_pkg;

   typedef enum logic [2:0] {
      CMD_NOP,
      CMD_ACT,
      CMD_RD,
      CMD_WR,
      CMD_PRE,
      CMD_REF,
      CMD_MRS,
      CMD_BST
   } cmd_e;

   localparam int unsigned NUM_RULES  = 10;
   localparam int unsigned ERR_CODE_W = 4;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdrchk_decode.sv
module sdrchk_decode
   import sdrchk_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);

   always_comb begin
      cmd = CMD_NOP;
      if (!cs_n) begin
         case ({ras_n, cas_n, we_n})
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b010:  cmd = CMD_PRE;
            3'b001:  cmd = CMD_REF;
            3'b000:  cmd = CMD_MRS;
            3'b110:  cmd = CMD_BST;
            default: cmd = CMD_NOP;
         endcase
      end
   end

endmodule

// File: rtl/sdrchk_bank.sv
module sdrchk_bank
   import sdrchk_pkg::*;
#(
   parameter int unsigned T_RCD     = 3,
   parameter int unsigned T_RP      = 3,
   parameter int unsigned T_RRD     = 2,
   parameter int unsigned T_RAS     = 6,
   parameter int unsigned T_RC      = 10,
   parameter int unsigned BURST_LEN = 4,
   parameter int unsigned TW        = 4
)(
   input  logic clk,
   input  logic rst_n,
   input  cmd_e cmd,
   input  logic sel,
   input  logic ap,
   output logic open,
   output logic recent,
   output logic v_open,
   output logic v_idle,
   output logic v_ap,
   output logic v_rcd,
   output logic v_rp,
   output logic v_ras,
   output logic v_rc
);

   localparam int unsigned AW = $clog2(BURST_LEN + 1);
   localparam logic [TW-1:0] SAT   = {TW{1'b1}};
   localparam logic [TW-1:0] L_RCD = TW'(T_RCD);
   localparam logic [TW-1:0] L_RP  = TW'(T_RP);
   localparam logic [TW-1:0] L_RRD = TW'(T_RRD);
   localparam logic [TW-1:0] L_RAS = TW'(T_RAS);
   localparam logic [TW-1:0] L_RC  = TW'(T_RC);

   logic          open_q;
   logic [TW-1:0] since_act;
   logic [TW-1:0] since_pre;
   logic [AW-1:0] ap_cnt;
   logic          act_me;
   logic          col_me;
   logic          pre_me;

   assign act_me = (cmd == CMD_ACT) && sel;
   assign col_me = ((cmd == CMD_RD) || (cmd == CMD_WR)) && sel;
   assign pre_me = (cmd == CMD_PRE) && (sel || ap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q    <= 1'b0;
         since_act <= SAT;
         since_pre <= SAT;
         ap_cnt    <= '0;
      end else begin
         if (since_act != SAT) since_act <= since_act + TW'(1);
         if (since_pre != SAT) since_pre <= since_pre + TW'(1);
         if (ap_cnt != '0) ap_cnt <= ap_cnt - AW'(1);
         if (ap_cnt == AW'(1)) begin
            open_q    <= 1'b0;
            since_pre <= TW'(1);
         end
         if (act_me && !open_q) begin
            open_q    <= 1'b1;
            since_act <= TW'(1);
         end
         if (col_me && open_q && (ap_cnt == '0) && ap) begin
            ap_cnt <= AW'(BURST_LEN);
         end
         if (pre_me && open_q) begin
            open_q    <= 1'b0;
            since_pre <= TW'(1);
            ap_cnt    <= '0;
         end
      end
   end

   assign open   = open_q;
   assign recent = (since_act < L_RRD);
   assign v_open = act_me && open_q;
   assign v_rp   = act_me && !open_q && (since_pre < L_RP);
   assign v_rc   = act_me && !open_q && (since_act < L_RC);
   assign v_idle = col_me && !open_q;
   assign v_ap   = col_me && open_q && (ap_cnt != '0);
   assign v_rcd  = col_me && open_q && (ap_cnt == '0) && (since_act < L_RCD);
   assign v_ras  = pre_me && open_q && (since_act < L_RAS);

   // R11
   ap_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ap_cnt != '0) |-> open_q)
      else $error("auto-precharge pending on a closed bank");

   // R11
   ap_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ap_cnt == AW'(1)) |=> !open_q)
      else $error("bank not closed at end of auto-precharge burst");

   // R2
   act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_me && !open_q) |=> open_q)
      else $error("activate did not open the bank");

endmodule

// File: rtl/sdrchk_log.sv
module sdrchk_log #(
   parameter int unsigned RULES  = 10,
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned CODE_W = 4
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic [RULES-1:0]       viol,
   output logic                   flag,
   output logic [CODE_W-1:0]      code,
   output logic [RULES*CNT_W-1:0] cnt
);

   logic [CODE_W-1:0] first_code;
   logic              flag_q;
   logic [CODE_W-1:0] code_q;

   always_comb begin
      first_code = '0;
      for (int i = int'(RULES) - 1; i >= 0; i--) begin
         if (viol[i]) first_code = CODE_W'(i + 1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         code_q <= '0;
      end else if (clr) begin
         flag_q <= 1'b0;
         code_q <= '0;
      end else if ((|viol) && !flag_q) begin
         flag_q <= 1'b1;
         code_q <= first_code;
      end
   end

   for (genvar gr = 0; gr < int'(RULES); gr++) begin : g_cnt
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           cnt_q <= '0;
         else if (clr)                         cnt_q <= '0;
         else if (viol[gr] && (cnt_q != '1))   cnt_q <= cnt_q + CNT_W'(1);
      end
      assign cnt[gr*CNT_W +: CNT_W] = cnt_q;
   end

   assign flag = flag_q;
   assign code = code_q;

   // R13
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr) |=> flag_q)
      else $error("error flag dropped without clear");

   // R13
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr) |=> $stable(code_q))
      else $error("latched code changed while flag set");

   // R13
   viol_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|viol) && !clr) |=> (flag_q && (code_q != '0)))
      else $error("violation did not set flag");

   // R13
   clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!flag_q && (code_q == '0) && (cnt == '0)))
      else $error("clear left state behind");

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
   import sdrchk_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned T_RCD     = 3,
   parameter int unsigned T_RP      = 3,
   parameter int unsigned T_RRD     = 2,
   parameter int unsigned T_RAS     = 6,
   parameter int unsigned T_RC      = 10,
   parameter int unsigned T_MRD     = 2,
   parameter int unsigned BURST_LEN = 4,
   parameter int unsigned CNT_W     = 8
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clr,
   input  logic                          cs_n,
   input  logic                          ras_n,
   input  logic                          cas_n,
   input  logic                          we_n,
   input  logic [$clog2(NUM_BANKS)-1:0]  ba,
   input  logic                          ap_bit,
   output logic                          err_flag,
   output logic [ERR_CODE_W-1:0]         err_code,
   output logic [NUM_RULES*CNT_W-1:0]    err_cnt
);

   localparam int unsigned BA_W = $clog2(NUM_BANKS);
   localparam int unsigned TMAX = max_u(max_u(max_u(T_RCD, T_RP), max_u(T_RRD, T_RAS)), T_RC);
   localparam int unsigned TW   = $clog2(TMAX + 1);
   localparam int unsigned MW   = $clog2(T_MRD + 1);

   if ((T_RCD == 0) || (T_RP == 0) || (T_RRD == 0) || (T_RAS == 0) ||
       (T_RC == 0) || (T_MRD == 0) || (BURST_LEN == 0)) begin : g_bad_time
      $error("timing parameters must be at least one cycle");
   end
   if ((NUM_BANKS < 2) || ((NUM_BANKS & (NUM_BANKS - 1)) != 0)) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (CNT_W == 0) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   cmd_e cmd;

   sdrchk_decode u_decode (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (cmd)
   );

   logic [NUM_BANKS-1:0] bk_open;
   logic [NUM_BANKS-1:0] bk_recent;
   logic [NUM_BANKS-1:0] vb_open;
   logic [NUM_BANKS-1:0] vb_idle;
   logic [NUM_BANKS-1:0] vb_ap;
   logic [NUM_BANKS-1:0] vb_rcd;
   logic [NUM_BANKS-1:0] vb_rp;
   logic [NUM_BANKS-1:0] vb_ras;
   logic [NUM_BANKS-1:0] vb_rc;

   for (genvar gi = 0; gi < int'(NUM_BANKS); gi++) begin : g_bank
      sdrchk_bank #(
         .T_RCD     (T_RCD),
         .T_RP      (T_RP),
         .T_RRD     (T_RRD),
         .T_RAS     (T_RAS),
         .T_RC      (T_RC),
         .BURST_LEN (BURST_LEN),
         .TW        (TW)
      ) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .cmd    (cmd),
         .sel    (ba == BA_W'(gi)),
         .ap     (ap_bit),
         .open   (bk_open[gi]),
         .recent (bk_recent[gi]),
         .v_open (vb_open[gi]),
         .v_idle (vb_idle[gi]),
         .v_ap   (vb_ap[gi]),
         .v_rcd  (vb_rcd[gi]),
         .v_rp   (vb_rp[gi]),
         .v_ras  (vb_ras[gi]),
         .v_rc   (vb_rc[gi])
      );
   end

   logic [MW-1:0]        since_mrs;
   logic [NUM_BANKS-1:0] ba_hot;
   logic                 v_mrd;
   logic                 v_busy;
   logic                 v_rrd;
   logic [NUM_RULES-1:0] viol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         since_mrs <= MW'(T_MRD);
      else if (cmd == CMD_MRS)            since_mrs <= MW'(1);
      else if (since_mrs != MW'(T_MRD))   since_mrs <= since_mrs + MW'(1);
   end

   assign ba_hot = NUM_BANKS'(1) << ba;
   assign v_mrd  = (cmd != CMD_NOP) && (since_mrs < MW'(T_MRD));
   assign v_busy = ((cmd == CMD_REF) || (cmd == CMD_MRS)) && (|bk_open);
   assign v_rrd  = (cmd == CMD_ACT) && !bk_open[ba] && (|(bk_recent & ~ba_hot));

   assign viol = {|vb_rc, |vb_ras, v_rrd, |vb_rp, |vb_rcd,
                  |vb_ap, |vb_idle, |vb_open, v_busy, v_mrd};

   sdrchk_log #(
      .RULES  (NUM_RULES),
      .CNT_W  (CNT_W),
      .CODE_W (ERR_CODE_W)
   ) u_log (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .viol  (viol),
      .flag  (err_flag),
      .code  (err_code),
      .cnt   (err_cnt)
   );

   // R10
   preall_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd == CMD_PRE) && ap_bit) |=> (bk_open == '0))
      else $error("precharge-all left a bank open");

   // R10
   single_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd == CMD_PRE) && !ap_bit) |=> !bk_open[$past(ba)])
      else $error("precharge left its bank open");

   // R4
   mrs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmd == CMD_MRS) && (cmd != CMD_NOP)) |-> viol[0])
      else $error("command right after mode-set not flagged");

endmodule

// File: tb/sdram_cmd_monitor_bench.sv
module sdram_cmd_monitor_bench;

   localparam int NB = 4, RCD = 3, RP = 3, RRD = 2, RAS = 6, RC = 10;
   localparam int MRD = 2, BL = 4, CW = 8, NR = 10;

   localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100;
   localparam logic [2:0] C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000, C_BST = 3'b110;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0, clr = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0] ba = '0;
   logic ap_bit = 1'b0;
   logic err_flag;
   logic [3:0] err_code;
   logic [NR*CW-1:0] err_cnt;

   sdram_cmd_monitor #(
      .NUM_BANKS(NB), .T_RCD(RCD), .T_RP(RP), .T_RRD(RRD), .T_RAS(RAS),
      .T_RC(RC), .T_MRD(MRD), .BURST_LEN(BL), .CNT_W(CW)
   ) u_sdram_cmd_monitor (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .ap_bit(ap_bit),
      .err_flag(err_flag), .err_code(err_code), .err_cnt(err_cnt)
   );

   int n_chk = 0, n_err = 0;

   // reference model state (timestamps in cycles)
   int t = 0, mrs_t = -1000;
   int act_t[NB], pre_t[NB], ap_end[NB];
   bit [NB-1:0] opn, apd;
   bit exp_flag;
   int exp_code;
   int exp_cnt[NR+1];

   function automatic string req_of(input int c);
      case (c)
         1: return "R4";   2: return "R3";   3: return "R2";  4: return "R2";
         5: return "R11";  6: return "R5";   7: return "R6";  8: return "R7";
         9: return "R8";   10: return "R9";  default: return "R13";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d at t=%0d", req, act, exp, t);
      end
   endtask

   task automatic model_step(input bit csn, input logic [2:0] rcw, input int b, input bit a, input bit cl);
      bit [NR:1] m = '0;
      for (int c = 0; c < NB; c++)
         if (apd[c] && (t > ap_end[c])) begin opn[c] = 0; apd[c] = 0; pre_t[c] = ap_end[c]; end
      if (!csn) begin
         if ((rcw != C_NOP) && (t - mrs_t < MRD)) m[1] = 1;
         case (rcw)
            C_MRS, C_REF: if (|opn) m[2] = 1;
            C_ACT: begin
               if (opn[b]) m[3] = 1;
               else begin
                  if (t - pre_t[b] < RP) m[7] = 1;
                  if (t - act_t[b] < RC) m[10] = 1;
                  for (int c = 0; c < NB; c++)
                     if ((c != b) && (t - act_t[c] < RRD)) m[8] = 1;
               end
            end
            C_RD, C_WR: begin
               if (!opn[b]) m[4] = 1;
               else if (apd[b]) m[5] = 1;
               else if (t - act_t[b] < RCD) m[6] = 1;
            end
            C_PRE: for (int c = 0; c < NB; c++)
               if (opn[c] && (a || c == b) && (t - act_t[c] < RAS)) m[9] = 1;
            default: ;
         endcase
         case (rcw)
            C_ACT: if (!opn[b]) begin opn[b] = 1; act_t[b] = t; end
            C_RD, C_WR: if (opn[b] && !apd[b] && a) begin apd[b] = 1; ap_end[b] = t + BL; end
            C_PRE: for (int c = 0; c < NB; c++)
               if (opn[c] && (a || c == b)) begin opn[c] = 0; apd[c] = 0; pre_t[c] = t; end
            C_MRS: mrs_t = t;
            default: ;
         endcase
      end
      if (cl) begin
         exp_flag = 0; exp_code = 0;
         for (int k = 1; k <= NR; k++) exp_cnt[k] = 0;
      end else begin
         for (int k = 1; k <= NR; k++) if (m[k] && exp_cnt[k] < 255) exp_cnt[k]++;
         if ((m != '0) && !exp_flag) begin
            exp_flag = 1;
            for (int k = NR; k >= 1; k--) if (m[k]) exp_code = k;
         end
      end
      t++;
   endtask

   task automatic compare_all();
      check(err_flag == exp_flag, "R13", int'(err_flag), int'(exp_flag));
      check(int'(err_code) == exp_code, req_of(exp_code), int'(err_code), exp_code);
      for (int k = 1; k <= NR; k++)
         check(int'(err_cnt[(k-1)*CW +: CW]) == exp_cnt[k], req_of(k),
               int'(err_cnt[(k-1)*CW +: CW]), exp_cnt[k]);
   endtask

   task automatic issue(input bit csn, input logic [2:0] rcw, input int b, input bit a, input bit cl);
      @(negedge clk);
      cs_n = csn; {ras_n, cas_n, we_n} = rcw; ba = 2'(b); ap_bit = a; clr = cl;
      @(posedge clk);
      model_step(csn, rcw, b, a, cl);
      #1;
      compare_all();
   endtask

   task automatic nops(input int n);
      for (int i = 0; i < n; i++) issue(0, C_NOP, 0, 0, 0);
   endtask

   task automatic setup();
      issue(0, C_PRE, 0, 1, 0);
      nops(12);
      issue(0, C_NOP, 0, 0, 1);
   endtask

   task automatic expect_code(input int c, input string r);
      check(err_flag && (int'(err_code) == c), r, int'(err_code), c);
   endtask

   task automatic expect_clean(input string r);
      check(!err_flag, r, int'(err_code), 0);
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int c = 0; c < NB; c++) begin act_t[c] = -1000; pre_t[c] = -1000; ap_end[c] = 0; end
      opn = '0; apd = '0; exp_flag = 0; exp_code = 0;
      for (int k = 0; k <= NR; k++) exp_cnt[k] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R13 reset state
      check(!err_flag && err_code == 0 && err_cnt == '0, "R13", int'(err_code), 0);

      // R1: deselect with command-like strobes does nothing
      setup(); issue(0, C_ACT, 0, 0, 0); issue(1, C_MRS, 0, 0, 0); issue(1, C_ACT, 0, 0, 0);
      expect_clean("R1");
      // R2
      setup(); issue(0, C_ACT, 1, 0, 0); nops(10); issue(0, C_ACT, 1, 0, 0); expect_code(3, "R2");
      setup(); issue(0, C_RD, 2, 0, 0); expect_code(4, "R2");
      // R3
      setup(); issue(0, C_ACT, 0, 0, 0); nops(10); issue(0, C_REF, 0, 0, 0); expect_code(2, "R3");
      // R4
      setup(); issue(0, C_MRS, 0, 0, 0); issue(0, C_ACT, 0, 0, 0); expect_code(1, "R4");
      setup(); issue(0, C_MRS, 0, 0, 0); nops(1); issue(0, C_ACT, 3, 0, 0); expect_clean("R4");
      // R5
      setup(); issue(0, C_ACT, 0, 0, 0); nops(RCD-2); issue(0, C_RD, 0, 0, 0); expect_code(6, "R5");
      setup(); issue(0, C_ACT, 0, 0, 0); nops(RCD-1); issue(0, C_RD, 0, 0, 0); expect_clean("R5");
      // R6
      setup(); issue(0, C_ACT, 0, 0, 0); nops(10); issue(0, C_PRE, 0, 0, 0); nops(RP-2);
      issue(0, C_ACT, 0, 0, 0); expect_code(7, "R6");
      setup(); issue(0, C_ACT, 0, 0, 0); nops(10); issue(0, C_PRE, 0, 0, 0); nops(RP-1);
      issue(0, C_ACT, 0, 0, 0); expect_clean("R6");
      // R7
      setup(); issue(0, C_ACT, 0, 0, 0); issue(0, C_ACT, 1, 0, 0); expect_code(8, "R7");
      setup(); issue(0, C_ACT, 0, 0, 0); nops(RRD-1); issue(0, C_ACT, 1, 0, 0); expect_clean("R7");
      // R8
      setup(); issue(0, C_ACT, 2, 0, 0); nops(RAS-2); issue(0, C_PRE, 2, 0, 0); expect_code(9, "R8");
      setup(); issue(0, C_ACT, 2, 0, 0); nops(RAS-1); issue(0, C_PRE, 2, 0, 0); expect_clean("R8");
      // R9
      setup(); issue(0, C_ACT, 0, 0, 0); nops(RAS-1); issue(0, C_PRE, 0, 0, 0); nops(2);
      issue(0, C_ACT, 0, 0, 0); expect_code(10, "R9");
      setup(); issue(0, C_ACT, 0, 0, 0); nops(RAS-1); issue(0, C_PRE, 0, 0, 0); nops(3);
      issue(0, C_ACT, 0, 0, 0); expect_clean("R9");
      // R10
      setup(); issue(0, C_ACT, 0, 0, 0); nops(2); issue(0, C_ACT, 1, 0, 0); nops(10);
      issue(0, C_PRE, 3, 1, 0); nops(10); issue(0, C_ACT, 0, 0, 0); nops(2); issue(0, C_ACT, 1, 0, 0);
      expect_clean("R10");
      setup(); issue(0, C_ACT, 2, 0, 0); nops(2); issue(0, C_ACT, 3, 0, 0); nops(10);
      issue(0, C_PRE, 2, 0, 0); nops(10); issue(0, C_ACT, 2, 0, 0); expect_clean("R10");
      nops(2); issue(0, C_ACT, 3, 0, 0); expect_code(3, "R10");
      // R11
      setup(); issue(0, C_ACT, 0, 0, 0); nops(RCD-1); issue(0, C_RD, 0, 1, 0); nops(1);
      issue(0, C_RD, 0, 0, 0); expect_code(5, "R11");
      setup(); issue(0, C_ACT, 0, 0, 0); nops(RAS); issue(0, C_WR, 0, 1, 0); nops(BL+RP-2);
      issue(0, C_ACT, 0, 0, 0); expect_code(7, "R11");
      setup(); issue(0, C_ACT, 0, 0, 0); nops(RAS); issue(0, C_WR, 0, 1, 0); nops(BL+RP-1);
      issue(0, C_ACT, 0, 0, 0); expect_clean("R11");
      // R12
      setup(); issue(0, C_ACT, 0, 0, 0); nops(RCD); issue(0, C_RD, 0, 0, 0); issue(0, C_RD, 0, 0, 0);
      issue(0, C_WR, 0, 0, 0); issue(0, C_RD, 0, 0, 0); expect_clean("R12");
      // R13: simultaneous violations, lowest code wins; sticky; clear
      setup(); issue(0, C_MRS, 0, 0, 0); issue(0, C_RD, 1, 0, 0); expect_code(1, "R13");
      check(err_cnt[3*CW +: CW] == 8'd1, "R13", int'(err_cnt[3*CW +: CW]), 1);
      nops(2); issue(0, C_RD, 2, 0, 0); expect_code(1, "R13");
      check(err_cnt[3*CW +: CW] == 8'd2, "R13", int'(err_cnt[3*CW +: CW]), 2);
      issue(0, C_RD, 2, 0, 1);
      check(!err_flag && err_code == 0 && err_cnt == '0, "R13", int'(err_code), 0);

      // constrained random stream against the model
      for (int i = 0; i < 3000; i++) begin
         int r = int'($urandom % 16);
         logic [2:0] rc;
         if (r < 5) rc = C_NOP; else if (r < 8) rc = C_ACT; else if (r < 10) rc = C_RD;
         else if (r == 10) rc = C_WR; else if (r < 13) rc = C_PRE; else if (r == 13) rc = C_REF;
         else if (r == 14) rc = C_MRS; else rc = C_BST;
         issue(($urandom % 8) == 0, rc, int'($urandom % 4), ($urandom % 3) == 0, ($urandom % 24) == 0);
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule